// File: doc/BRIEF.md
# Read-back Checking Serial Transmitter

This block shifts 11-bit frames onto a shared single-wire or wired-AND line. Each frame is a low start bit, nine data bits with the least significant first, and a high stop bit. While a frame is on the line, the block reads the line back on `rxd` and compares it with the bit it is driving. A difference raises a sticky collision flag, which serves as an interrupt request. Bit timing comes from the `tick` clock enable; baud-rate generation lives outside the block.

Four configuration inputs shape the behaviour:

- `cfg_smp_sel` picks the comparison instant: every `tick`, or an external one-cycle `strobe` from a separate one-shot timer.
- `cfg_auto_clr` makes a collision drop the transmit enable and abort the frame.
- `cfg_edge_start` picks how a frame begins: a fixed one-bit delay after the start condition, or a qualifying edge on the line.
- `cfg_rx_inv` inverts the sense of the read-back line after synchronisation.

Software loads the holding register with `hold_wr`. It controls the enable with `en_set` and `en_clr`, and clears the collision flag with `flag_clr`.

Top module: `uart_bc_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0, `collide` is 0 and `tx_en` is 0.
- R2: With `cfg_edge_start`=0, the start condition is `tx_en`=1 with a loaded holding register and no frame in progress. The first `tick` with that condition arms the transmitter and leaves `txd` at 1. The next `tick` starts the frame: `busy`=1 and `txd`=0 in the cycle after that tick.
- R3: A frame drives `txd` low for the start bit, then data bits 0 through 8 in that order, then high for the stop bit. `txd` advances one bit per `tick`. The `tick` that ends the stop bit returns `busy` to 0, and `txd` idles at 1.
- R4: With `cfg_edge_start`=1 and the start condition met, a qualifying edge on raw `rxd` sets `busy`=1 and `txd`=0 on the third clock edge after the change. No `tick` is needed.
- R5: The qualifying edge is a falling edge of the line after polarity correction. This is a raw falling edge when `cfg_rx_inv`=0 and a raw rising edge when `cfg_rx_inv`=1. An edge in the opposite direction starts nothing.
- R6: A qualifying edge seen while the start condition is not met (enable off or holding register empty) does not start a frame, and is not remembered for later.
- R7: With `cfg_smp_sel`=0, a `tick` during a frame at which the driven bit differs from the synchronised, polarity-corrected `rxd` sets `collide` in the next cycle.
- R8: With `cfg_smp_sel`=1, only `strobe` triggers the comparison; a mismatch present at a `tick` sets nothing.
- R9: `collide` stays 1 until `flag_clr` is pulsed. A new mismatch takes priority over a clear in the same cycle.
- R10: With `cfg_auto_clr`=1, the cycle in which `collide` rises also shows `tx_en`=0, `busy`=0 and `txd`=1. With `cfg_auto_clr`=0, the frame and the enable continue.
- R11: No comparison happens while `busy` is 0. A line mismatch at `tick` or `strobe` outside a frame leaves `collide` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Bit-clock enable, one cycle per bit period |
| strobe | input | 1 | External one-cycle sampling strobe |
| cfg_smp_sel | input | 1 | 0: compare at `tick`, 1: compare at `strobe` |
| cfg_auto_clr | input | 1 | 1: a collision clears the enable and aborts the frame |
| cfg_edge_start | input | 1 | 0: start one bit after the condition, 1: start on a line edge |
| cfg_rx_inv | input | 1 | 1: invert the read-back line |
| en_set | input | 1 | Pulse to set the transmit enable |
| en_clr | input | 1 | Pulse to clear the transmit enable |
| hold_wr | input | 1 | Pulse to load `hold_data` into the holding register |
| hold_data | input | 9 | Frame data |
| flag_clr | input | 1 | Pulse to clear `collide` |
| rxd | input | 1 | Read-back of the line, asynchronous |
| txd | output | 1 | Transmit line, idle 1 |
| tx_en | output | 1 | Current transmit enable |
| busy | output | 1 | A frame is being shifted out |
| collide | output | 1 | Sticky collision flag / interrupt request |

## Verification
Every result of a `tick` or `strobe` appears one clock after the edge that samples the pulse. The bench therefore raises the pulse just after a falling edge and checks the outputs at the next falling edge. A line change reaches the comparison and the edge detector only after two synchroniser flops. For that reason the bench changes the line at least three cycles before the `tick` or `strobe` that must see it. In edge-start mode it checks that `busy` is still 0 two cycles after the raw change and is 1 one cycle later. Each scenario that sets the collision flag then checks, several ticks later and before the clear, that the flag is still 1.

// File: rtl/uart_bc_tx.sv
module uart_bc_tx #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          strobe,
  input  logic          cfg_smp_sel,
  input  logic          cfg_auto_clr,
  input  logic          cfg_edge_start,
  input  logic          cfg_rx_inv,
  input  logic          en_set,
  input  logic          en_clr,
  input  logic          hold_wr,
  input  logic [DW-1:0] hold_data,
  input  logic          flag_clr,
  input  logic          rxd,
  output logic          txd,
  output logic          tx_en,
  output logic          busy,
  output logic          collide
);
  localparam int FW = DW + 2;
  localparam int CW = $clog2(FW);

  logic [2:0]    rs;
  logic          en_q, full_q, arm_q, busy_q, flag_q;
  logic [DW-1:0] hold_q;
  logic [FW-1:0] sr;
  logic [CW-1:0] cnt;

  logic rx_now, rx_old, rx_fall, smp, hit, ready, go, kill;

  assign rx_now  = rs[1] ^ cfg_rx_inv;
  assign rx_old  = rs[2] ^ cfg_rx_inv;
  assign rx_fall = rx_old & ~rx_now;
  assign smp     = cfg_smp_sel ? strobe : tick;
  assign hit     = busy_q & smp & (sr[0] != rx_now);
  assign kill    = hit & cfg_auto_clr;
  assign ready   = en_q & full_q & ~busy_q;
  assign go      = ready & (cfg_edge_start ? rx_fall : (arm_q & tick));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs <= '1;
    else        rs <= {rs[1:0], rxd};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        flag_q <= 1'b0;
    else if (hit)      flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      en_q <= 1'b0;
    else if (kill)   en_q <= 1'b0;
    else if (en_clr) en_q <= 1'b0;
    else if (en_set) en_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                           arm_q <= 1'b0;
    else if (go || !ready || cfg_edge_start) arm_q <= 1'b0;
    else if (tick)                        arm_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else if (hold_wr) begin
      full_q <= 1'b1;
      hold_q <= hold_data;
    end else if (go) begin
      full_q <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q <= 1'b0;
      sr     <= '1;
      cnt    <= '0;
    end else if (kill) begin
      busy_q <= 1'b0;
      sr     <= '1;
    end else if (go) begin
      busy_q <= 1'b1;
      sr     <= {1'b1, hold_q, 1'b0};
      cnt    <= '0;
    end else if (busy_q && tick) begin
      if (cnt == CW'(FW - 1)) begin
        busy_q <= 1'b0;
        sr     <= '1;
      end else begin
        sr  <= {1'b1, sr[FW-1:1]};
        cnt <= cnt + 1'b1;
      end
    end

  assign txd     = busy_q ? sr[0] : 1'b1;
  assign tx_en   = en_q;
  assign busy    = busy_q;
  assign collide = flag_q;
endmodule

// File: rtl/uart_bc_tx_chk.sv
module uart_bc_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic strobe,
  input logic cfg_smp_sel,
  input logic cfg_auto_clr,
  input logic flag_clr,
  input logic txd,
  input logic tx_en,
  input logic busy,
  input logic collide
);
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !txd); // R3
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(tx_en)); // R6
  AST_STROBE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) cfg_smp_sel && !strobe && !collide |=> !collide); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) collide && !flag_clr |=> collide); // R9
  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) $rose(collide) && $past(cfg_auto_clr) |-> !tx_en && !busy && txd); // R10
  AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n) !busy && !collide |=> !collide); // R11
endmodule

bind uart_bc_tx uart_bc_tx_chk chk_i (.*);

// File: tb/uart_bc_tx_tb_top.sv
`timescale 1ns/1ps
module uart_bc_tx_tb_top;
  logic clk = 0, rst_n = 0;
  logic tick = 0, strobe = 0;
  logic cfg_smp_sel = 0, cfg_auto_clr = 0, cfg_edge_start = 0, cfg_rx_inv = 0;
  logic en_set = 0, en_clr = 0, hold_wr = 0, flag_clr = 0;
  logic [8:0] hold_data = '0;
  logic pull = 0;
  logic rxd, txd, tx_en, busy, collide;
  int total = 0, bad = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;
  assign rxd = (txd & ~pull) ^ cfg_rx_inv;

  uart_bc_tx dut_i (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_tick;
    tick = 1; @(negedge clk); tick = 0;
  endtask

  task automatic do_strobe;
    strobe = 1; @(negedge clk); strobe = 0;
  endtask

  task automatic bit_tick;
    step(3); do_tick;
  endtask

  task automatic load_enable(logic [8:0] d);
    hold_data = d; hold_wr = 1; en_set = 1;
    @(negedge clk);
    hold_wr = 0; en_set = 0;
  endtask

  task automatic disable_tx;
    en_clr = 1; @(negedge clk); en_clr = 0;
  endtask

  task automatic clear_flag;
    flag_clr = 1; @(negedge clk); flag_clr = 0;
  endtask

  task automatic t_reset;
    chk("R1 txd", txd, 1);
    chk("R1 busy", busy, 0);
    chk("R1 collide", collide, 0);
    chk("R1 tx_en", tx_en, 0);
  endtask

  task automatic t_delay_frame(logic [8:0] d, logic inv);
    cfg_edge_start = 0; cfg_rx_inv = inv;
    step(4);
    load_enable(d);
    bit_tick;
    chk("R2 armed busy", busy, 0);
    chk("R2 armed txd", txd, 1);
    bit_tick;
    chk("R2 start busy", busy, 1);
    chk("R2 start txd", txd, 0);
    for (int k = 0; k < 9; k++) begin
      bit_tick;
      chk($sformatf("R3 data bit %0d", k), txd, d[k]);
    end
    bit_tick;
    chk("R3 stop", txd, 1);
    chk("R3 busy in stop", busy, 1);
    bit_tick;
    chk("R3 end busy", busy, 0);
    chk("R3 idle txd", txd, 1);
    chk("R7 clean frame no flag", collide, 0);
    disable_tx;
    cfg_rx_inv = 0;
  endtask

  task automatic t_edge_start(logic [8:0] d, logic inv);
    cfg_edge_start = 1; cfg_rx_inv = inv;
    step(4);
    pull = 1; step(4);
    chk("R6 edge before enable", busy, 0);
    load_enable(d);
    step(2);
    pull = 0; step(4);
    chk("R5 opposite edge ignored", busy, 0);
    chk("R6 early edge not kept", txd, 1);
    pull = 1; step(2);
    chk("R4 not yet started", busy, 0);
    step(1);
    chk("R4 edge start busy", busy, 1);
    chk("R4 edge start txd", txd, 0);
    pull = 0;
    for (int k = 0; k < 9; k++) begin
      bit_tick;
      chk($sformatf("R4 data bit %0d", k), txd, d[k]);
    end
    bit_tick;
    chk("R3 stop edge mode", txd, 1);
    bit_tick;
    chk("R3 end edge mode", busy, 0);
    chk("R7 edge frame no flag", collide, 0);
    disable_tx;
    cfg_edge_start = 0; cfg_rx_inv = 0;
    step(4);
  endtask

  task automatic t_collide_tick(logic auto);
    cfg_edge_start = 0; cfg_smp_sel = 0; cfg_auto_clr = auto;
    load_enable(9'h1FF);
    bit_tick; bit_tick;
    bit_tick;
    chk("R7 D0 driven", txd, 1);
    pull = 1;
    bit_tick;
    chk("R7 collide set", collide, 1);
    if (auto) begin
      chk("R10 en cleared", tx_en, 0);
      chk("R10 aborted", busy, 0);
      chk("R10 txd idle", txd, 1);
      pull = 0;
      bit_tick; bit_tick;
      chk("R10 stays idle", busy, 0);
    end else begin
      chk("R10 no auto en kept", tx_en, 1);
      chk("R10 no auto busy kept", busy, 1);
      pull = 0;
      repeat (9) bit_tick;
      chk("R10 no auto frame ends", busy, 0);
    end
    chk("R9 sticky", collide, 1);
    clear_flag;
    chk("R9 cleared", collide, 0);
    if (!auto) disable_tx;
    cfg_auto_clr = 0;
  endtask

  task automatic t_strobe;
    cfg_edge_start = 0; cfg_smp_sel = 1; cfg_auto_clr = 0;
    load_enable(9'h1FF);
    bit_tick; bit_tick; bit_tick;
    pull = 1;
    bit_tick;
    chk("R8 tick ignored", collide, 0);
    step(3);
    do_strobe;
    chk("R8 strobe sets", collide, 1);
    pull = 0;
    repeat (9) bit_tick;
    chk("R8 frame done", busy, 0);
    chk("R9 sticky after frame", collide, 1);
    clear_flag;
    chk("R9 clear", collide, 0);
    disable_tx;
    cfg_smp_sel = 0;
  endtask

  task automatic t_idle;
    pull = 1; step(3);
    do_tick;
    chk("R11 idle tick", collide, 0);
    cfg_smp_sel = 1;
    do_strobe;
    chk("R11 idle strobe", collide, 0);
    cfg_smp_sel = 0; pull = 0;
    step(4);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step(2);
    t_reset;
    t_delay_frame(9'h0A5, 0);
    t_delay_frame(9'h15A, 0);
    t_delay_frame(9'h1C3, 1);
    t_edge_start(9'h12D, 0);
    t_edge_start(9'h0F0, 1);
    t_collide_tick(0);
    t_collide_tick(1);
    t_strobe;
    t_idle;
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule